// File: doc/BRIEF.md
# Configuration Unlock and Flash Settings Port

This block is the configuration front end of an I/O controller. It sits on a simple byte-wide host I/O bus that carries a port address, a write strobe and a read strobe. After reset it is locked: the host must write a fixed four-byte key to the index port before any configuration register can be seen. The index port is at the strapped base address and the data port is one address above it. The final key byte depends on which of the two base addresses is strapped.

Once unlocked, the host writes a register number to the index port and then reads or writes that register through the data port. The register space holds a read-only chip identifier and version byte, a feature register and a logical-device selector. The feature register carries a suspend flag, three serial-flash segment enables, a host-write-to-flash enable and a pin-routing select. When the flash logical device is selected, two registers hold the high and low bytes of the flash command port base. The block reports whether that base is usable. Writing the exit code to the control register locks the block again.

The feature bits, the port base and its validity flag are driven straight out as registered outputs, so the rest of the chip can use them.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked. The feature register holds 0x02, so segment enable bit 0 is on and the suspend, write-enable and pin-select outputs are 0. The logical-device select holds 0x00 and the flash port base is 0x0820.
- R2: The index port is base and the data port is base+1. Base is 0x002E when `basePortSel`=0 and 0x004E when `basePortSel`=1. Index-port writes of 0x87, 0x01, 0x55 and then a last byte unlock the block on the clock edge of that last write. The last byte is 0x55 for base 0x2E and 0xAA for base 0x4E. Accesses to any other address have no effect.
- R3: While locked, an index-port byte that does not match the expected key byte restarts matching. If that byte is 0x87, it counts as the first key byte.
- R4: While locked, data-port reads return 0xFF and data-port writes change nothing.
- R5: While unlocked, writing 0x02 to register 0x02 locks the block and clears the index to 0x00. Any other value written there has no effect. Register 0x02 reads 0x00.
- R6: Register 0x20 reads 0x87 (ID high byte), register 0x21 reads 0x16 (ID low byte) and register 0x22 reads 0x01 (version). Writes to these registers are ignored.
- R7: Register 0x24 is read/write, and all 8 bits read back. Its bits drive the outputs as follows: bit 0 is `flashSuspend`, bits 3:1 are `flashSegEn[2:0]`, bit 4 is `lpcFlashWrEn` and bit 5 is `flashPinSel`.
- R8: Register 0x07 is the read/write logical-device select. With it set to 0x07, register 0x64 holds the high byte and register 0x65 the low byte of `flashPortBase`. With any other value, those registers read 0x00 and writes to them are ignored.
- R9: `flashPortValid` is 1 exactly when `flashPortBase` is nonzero, below 0x1000 and a multiple of 8.
- R10: Registers that are not listed read 0x00. A read that is not a data-port read returns 0x00.
- R11: A data-port read and write in the same cycle returns the register value from before the write; the write takes effect on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| basePortSel | input | 1 | Base strap: 0 selects 0x2E, 1 selects 0x4E |
| ioWrEn | input | 1 | Host write strobe, one cycle per byte |
| ioRdEn | input | 1 | Host read strobe |
| ioAddr | input | 16 | Host I/O port address |
| ioWrData | input | 8 | Host write byte |
| ioRdData | output | 8 | Read byte, combinational during `ioRdEn` |
| cfgUnlocked | output | 1 | Configuration space is open |
| flashSuspend | output | 1 | Suspend flag, feature bit 0 |
| flashSegEn | output | 3 | Serial-flash segment enables |
| lpcFlashWrEn | output | 1 | Host writes to flash allowed |
| flashPinSel | output | 1 | Flash interface pin routing |
| flashPortBase | output | 16 | Flash command port base |
| flashPortValid | output | 1 | Port base satisfies the validity rule |

## Verification
A data-port read and a data-port write can fall in the same cycle. The read path is combinational from the register file and the write lands on the following edge, so the two can overlap. Two other events can also coincide: the relock write and a read of the control register, and a key-byte write that both mismatches and restarts matching. The bench provokes the read/write overlap with directed cycles on the feature and port registers and with random cycles that raise both strobes together. A shadow model judges the read against the pre-write value and then checks every registered output against the post-write value.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
package sio_cfg_pkg;
  localparam int KEY_LEN = 4;
  localparam int KEY_CW = $clog2(KEY_LEN);
  localparam int PORT_BYTES = 2;

  localparam logic [7:0] IDX_CTRL    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_VER     = 8'h22;
  localparam logic [7:0] IDX_FEAT    = 8'h24;
  localparam logic [7:0] IDX_PORT_LO = 8'h65;
  localparam logic [7:0] EXIT_CODE   = 8'h02;
  localparam logic [7:0] LOCKED_READ = 8'hFF;

  typedef struct packed {
    logic                  wrLdn;
    logic                  wrFeat;
    logic [PORT_BYTES-1:0] wrPort;   // bit g writes port byte g (0 = low)
    logic [7:0]            data;
  } cfgStrobe_t;

  function automatic logic [7:0] keyByte(input logic [KEY_CW-1:0] step, input logic altBase);
    case (step)
      2'd0:    keyByte = 8'h87;
      2'd1:    keyByte = 8'h01;
      2'd2:    keyByte = 8'h55;
      default: keyByte = altBase ? 8'hAA : 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/sio_cfg_ctrl.sv
`timescale 1ns/1ps
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_A = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_B = 16'h004E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              basePortSel,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  output logic              unlocked,
  output logic [7:0]        cfgIndex,
  output logic              dataRd,
  output cfgStrobe_t        strobe
);
  localparam logic [KEY_CW-1:0] KEY_LAST = KEY_CW'(KEY_LEN - 1);

  logic [ADDR_W-1:0] baseAddr;
  logic              idxHit, dataHit, idxWr, dataWr, exitWr;
  logic [KEY_CW-1:0] keyCount;

  always_comb begin
    baseAddr = basePortSel ? BASE_B : BASE_A;
    idxHit   = (ioAddr == baseAddr);
    dataHit  = (ioAddr == ADDR_W'(baseAddr + 1'b1));
    idxWr    = ioWrEn && idxHit;
    dataWr   = ioWrEn && dataHit && unlocked;
    exitWr   = dataWr && (cfgIndex == IDX_CTRL) && (ioWrData == EXIT_CODE);
    dataRd   = ioRdEn && dataHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      keyCount <= '0;
      cfgIndex <= '0;
    end else if (idxWr) begin
      if (!unlocked) begin
        if (ioWrData == keyByte(keyCount, basePortSel)) begin
          if (keyCount == KEY_LAST) begin
            unlocked <= 1'b1;
            keyCount <= '0;
          end else begin
            keyCount <= keyCount + KEY_CW'(1);
          end
        end else if (ioWrData == keyByte('0, basePortSel)) begin
          keyCount <= KEY_CW'(1);
        end else begin
          keyCount <= '0;
        end
      end else begin
        cfgIndex <= ioWrData;
      end
    end else if (exitWr) begin
      unlocked <= 1'b0;
      cfgIndex <= '0;
    end
  end

  always_comb begin
    strobe.wrLdn  = dataWr && (cfgIndex == IDX_LDN);
    strobe.wrFeat = dataWr && (cfgIndex == IDX_FEAT);
    for (int g = 0; g < PORT_BYTES; g++)
      strobe.wrPort[g] = dataWr && (cfgIndex == IDX_PORT_LO - 8'(g));
    strobe.data = ioWrData;
  end

  // R2: unlocking happens only on the last key byte
  assert_unlock_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(idxWr && keyCount == KEY_LAST));
  // R3: a first-key byte while locked always leaves matching at step two
  assert_key_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (idxWr && !unlocked && ioWrData == 8'h87) |=> (keyCount == KEY_CW'(1)));
  // R4: no register strobe while locked
  assert_locked_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> (!strobe.wrLdn && !strobe.wrFeat && strobe.wrPort == '0));
  // R5: exit code in the control register relocks
  assert_relock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && ioWrEn && dataHit && cfgIndex == IDX_CTRL && ioWrData == EXIT_CODE)
      |=> (!unlocked && cfgIndex == 8'h00));
endmodule

// File: rtl/sio_cfg_regs.sv
`timescale 1ns/1ps
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID    = 16'h8716,
  parameter logic [7:0]  VERSION    = 8'h01,
  parameter logic [7:0]  FEAT_RESET = 8'h02,
  parameter logic [15:0] PORT_RESET = 16'h0820,
  parameter logic [7:0]  FLASH_LDN  = 8'h07,
  parameter int          PORT_LIMIT = 'h1000,
  parameter int          PORT_ALIGN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strobe,
  input  logic [7:0] cfgIndex,
  output logic [7:0] cfgRdData,
  output logic [7:0] featReg,
  output logic [15:0] flashPortBase,
  output logic       flashPortValid
);
  localparam int ALIGN_BITS = $clog2(PORT_ALIGN);

  logic [7:0] ldnReg;
  logic [7:0] portByte [PORT_BYTES];
  logic       flashSel;

  assign flashSel = (ldnReg == FLASH_LDN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldnReg  <= '0;
      featReg <= FEAT_RESET;
    end else begin
      if (strobe.wrLdn)  ldnReg  <= strobe.data;
      if (strobe.wrFeat) featReg <= strobe.data;
    end
  end

  for (genvar g = 0; g < PORT_BYTES; g++) begin : gPortByte
    always_ff @(posedge clk) begin
      if (!rstN)                           portByte[g] <= PORT_RESET[8*g +: 8];
      else if (strobe.wrPort[g] && flashSel) portByte[g] <= strobe.data;
    end
    assign flashPortBase[8*g +: 8] = portByte[g];
  end

  assign flashPortValid = (flashPortBase != '0) && (32'(flashPortBase) < PORT_LIMIT)
                          && (flashPortBase[ALIGN_BITS-1:0] == '0);

  always_comb begin
    cfgRdData = 8'h00;
    case (cfgIndex)
      IDX_ID_HI: cfgRdData = CHIP_ID[15:8];
      IDX_ID_LO: cfgRdData = CHIP_ID[7:0];
      IDX_VER:   cfgRdData = VERSION;
      IDX_LDN:   cfgRdData = ldnReg;
      IDX_FEAT:  cfgRdData = featReg;
      default:   cfgRdData = 8'h00;
    endcase
    for (int g = 0; g < PORT_BYTES; g++)
      if (flashSel && cfgIndex == IDX_PORT_LO - 8'(g)) cfgRdData = portByte[g];
  end

  // R7: feature write lands on the next edge
  assert_feat_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrFeat |=> (featReg == $past(strobe.data)));
  // R8: port base holds without a port strobe
  assert_port_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrPort == '0) |=> $stable(flashPortBase));
  // R8: port base holds when the flash device is not selected
  assert_port_ldn_R8: assert property (@(posedge clk) disable iff (!rstN)
    !flashSel |=> $stable(flashPortBase));
endmodule

// File: rtl/sio_cfg_port.sv
`timescale 1ns/1ps
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] BASE_A     = 16'h002E,
  parameter logic [15:0] BASE_B     = 16'h004E,
  parameter logic [15:0] CHIP_ID    = 16'h8716,
  parameter logic [7:0]  VERSION    = 8'h01,
  parameter logic [7:0]  FEAT_RESET = 8'h02,
  parameter logic [15:0] PORT_RESET = 16'h0820
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              basePortSel,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  output logic              cfgUnlocked,
  output logic              flashSuspend,
  output logic [2:0]        flashSegEn,
  output logic              lpcFlashWrEn,
  output logic              flashPinSel,
  output logic [15:0]       flashPortBase,
  output logic              flashPortValid
);
  cfgStrobe_t strobe;
  logic [7:0] cfgIndex, cfgRdData, featReg;
  logic       dataRd;

  sio_cfg_ctrl #(.ADDR_W(ADDR_W), .BASE_A(ADDR_W'(BASE_A)), .BASE_B(ADDR_W'(BASE_B))) i_ctrl (
    .clk(clk), .rstN(rstN), .basePortSel(basePortSel), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioAddr(ioAddr), .ioWrData(ioWrData), .unlocked(cfgUnlocked), .cfgIndex(cfgIndex),
    .dataRd(dataRd), .strobe(strobe));

  sio_cfg_regs #(.CHIP_ID(CHIP_ID), .VERSION(VERSION), .FEAT_RESET(FEAT_RESET),
                 .PORT_RESET(PORT_RESET)) i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgIndex(cfgIndex), .cfgRdData(cfgRdData),
    .featReg(featReg), .flashPortBase(flashPortBase), .flashPortValid(flashPortValid));

  always_comb begin
    if (!dataRd)           ioRdData = 8'h00;
    else if (!cfgUnlocked) ioRdData = LOCKED_READ;
    else                   ioRdData = cfgRdData;
  end

  assign flashSuspend = featReg[0];
  assign flashSegEn   = featReg[3:1];
  assign lpcFlashWrEn = featReg[4];
  assign flashPinSel  = featReg[5];

  // R4: locked data reads see all ones
  assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgUnlocked && dataRd) |-> (ioRdData == 8'hFF));
  // R10: no data-port read, no data
  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ioRdEn |-> (ioRdData == 8'h00));
endmodule

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
module test_sio_cfg_port;
  logic clk = 1'b0, rstN = 1'b0, basePortSel = 1'b0;
  logic ioWrEn = 1'b0, ioRdEn = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic cfgUnlocked, flashSuspend, lpcFlashWrEn, flashPinSel, flashPortValid;
  logic [2:0]  flashSegEn;
  logic [15:0] flashPortBase;

  int checks = 0, errors = 0;

  // shadow model
  logic mUnl, mSel;
  logic [1:0] mCnt;
  logic [7:0] mIdx, mLdn, mFeat, mHi, mLo;

  always #4 clk = ~clk;

  sio_cfg_port i_sio_cfg_port (
    .clk(clk), .rstN(rstN), .basePortSel(basePortSel), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioAddr(ioAddr), .ioWrData(ioWrData), .ioRdData(ioRdData), .cfgUnlocked(cfgUnlocked),
    .flashSuspend(flashSuspend), .flashSegEn(flashSegEn), .lpcFlashWrEn(lpcFlashWrEn),
    .flashPinSel(flashPinSel), .flashPortBase(flashPortBase), .flashPortValid(flashPortValid));

  function automatic logic [15:0] idxPort(); return mSel ? 16'h004E : 16'h002E; endfunction
  function automatic logic [15:0] datPort(); return idxPort() + 16'd1; endfunction
  function automatic logic [15:0] otherPort(); return mSel ? 16'h002E : 16'h004E; endfunction

  function automatic logic [7:0] keyOf(input logic [1:0] s);
    case (s)
      2'd0: return 8'h87;
      2'd1: return 8'h01;
      2'd2: return 8'h55;
      default: return mSel ? 8'hAA : 8'h55;
    endcase
  endfunction

  function automatic logic validOf(input logic [15:0] b);
    return (b != 0) && (b < 16'h1000) && (b[2:0] == 3'b000);
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] a);
    if (a != datPort()) return 8'h00;
    if (!mUnl) return 8'hFF;
    case (mIdx)
      8'h20: return 8'h87;
      8'h21: return 8'h16;
      8'h22: return 8'h01;
      8'h07: return mLdn;
      8'h24: return mFeat;
      8'h64: return (mLdn == 8'h07) ? mHi : 8'h00;
      8'h65: return (mLdn == 8'h07) ? mLo : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelWrite(input logic [15:0] a, input logic [7:0] d);
    if (a == idxPort()) begin
      if (!mUnl) begin
        if (d == keyOf(mCnt)) begin
          if (mCnt == 2'd3) begin mUnl = 1'b1; mCnt = 2'd0; end
          else mCnt = mCnt + 2'd1;
        end else mCnt = (d == 8'h87) ? 2'd1 : 2'd0;
      end else mIdx = d;
    end else if (a == datPort() && mUnl) begin
      case (mIdx)
        8'h02: if (d == 8'h02) begin mUnl = 1'b0; mIdx = 8'h00; end
        8'h07: mLdn = d;
        8'h24: mFeat = d;
        8'h64: if (mLdn == 8'h07) mHi = d;
        8'h65: if (mLdn == 8'h07) mLo = d;
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chkOutputs(input string req);
    chk(req, {8'h0, cfgUnlocked, flashSuspend, flashSegEn, lpcFlashWrEn, flashPinSel,
              flashPortBase, flashPortValid},
        {8'h0, mUnl, mFeat[0], mFeat[3:1], mFeat[4], mFeat[5], {mHi, mLo}, validOf({mHi, mLo})});
  endtask

  task automatic busCycle(input bit doWr, input bit doRd, input logic [15:0] a,
                          input logic [7:0] d, input string req);
    @(negedge clk);
    ioWrEn = doWr; ioRdEn = doRd; ioAddr = a; ioWrData = d;
    #1;
    if (doRd) chk({req, " read"}, ioRdData, expRead(a));
    @(posedge clk); #1;
    ioWrEn = 1'b0; ioRdEn = 1'b0;
    if (doWr) modelWrite(a, d);
    chkOutputs({req, " outputs"});
  endtask

  task automatic applyReset(input logic sel);
    @(negedge clk);
    rstN = 1'b0; basePortSel = sel; mSel = sel;
    mUnl = 0; mCnt = 0; mIdx = 0; mLdn = 0; mFeat = 8'h02; mHi = 8'h08; mLo = 8'h20;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
    busCycle(1'b1, 1'b0, a, d, req);
  endtask
  task automatic rd(input logic [15:0] a, input string req);
    busCycle(1'b0, 1'b1, a, 8'h00, req);
  endtask
  task automatic unlock(input string req);
    for (int k = 0; k < 4; k++) wr(idxPort(), keyOf(2'(k)), req);
  endtask
  task automatic setReg(input logic [7:0] idx, input logic [7:0] d, input string req);
    wr(idxPort(), idx, req);
    wr(datPort(), d, req);
  endtask
  task automatic getReg(input logic [7:0] idx, input string req);
    wr(idxPort(), idx, req);
    rd(datPort(), req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd7341);
    applyReset(1'b0);
    // R1 reset state
    #1 chkOutputs("R1 reset");
    chk("R1 reset locked", {31'd0, cfgUnlocked}, 32'd0);
    // R4 locked accesses
    rd(datPort(), "R4 locked read");
    wr(datPort(), 8'h3F, "R4 locked write");
    // R3 wrong byte, then 0x87 restarts
    wr(idxPort(), 8'h87, "R3"); wr(idxPort(), 8'h01, "R3"); wr(idxPort(), 8'hAA, "R3");
    chk("R3 wrong last byte stays locked", {31'd0, cfgUnlocked}, 32'd0);
    wr(idxPort(), 8'h87, "R3"); wr(idxPort(), 8'h87, "R3 restart on 0x87");
    wr(idxPort(), 8'h01, "R3"); wr(idxPort(), 8'h55, "R3"); wr(idxPort(), 8'h55, "R3");
    chk("R3 unlock after restart", {31'd0, cfgUnlocked}, 32'd1);
    // R4 earlier locked write did nothing
    getReg(8'h24, "R4 feat untouched");
    // R6 id and version, write ignored
    getReg(8'h20, "R6 id hi"); getReg(8'h21, "R6 id lo"); getReg(8'h22, "R6 version");
    setReg(8'h20, 8'h00, "R6 write ignored"); rd(datPort(), "R6 id hi after write");
    // R7 feature fields
    setReg(8'h24, 8'h35, "R7 fields"); rd(datPort(), "R7 readback");
    setReg(8'h24, 8'h0A, "R7 fields");
    // R10 unmapped and index-port read
    getReg(8'h55, "R10 unmapped"); rd(idxPort(), "R10 index read");
    // R8 port gated by device select
    setReg(8'h64, 8'h01, "R8 gated write"); rd(datPort(), "R8 gated read");
    setReg(8'h07, 8'h07, "R8 select"); rd(datPort(), "R8 select readback");
    getReg(8'h64, "R8 hi"); getReg(8'h65, "R8 lo");
    // R9 validity corners
    setReg(8'h64, 8'h00, "R9"); setReg(8'h65, 8'h00, "R9 zero invalid");
    setReg(8'h64, 8'h10, "R9 0x1000 invalid");
    setReg(8'h64, 8'h0F, "R9"); setReg(8'h65, 8'hF8, "R9 0x0FF8 valid");
    setReg(8'h64, 8'h01, "R9"); setReg(8'h65, 8'h04, "R9 unaligned invalid");
    setReg(8'h65, 8'h00, "R9 0x0100 valid");
    // R11 same-cycle read and write
    wr(idxPort(), 8'h24, "R11");
    busCycle(1'b1, 1'b1, datPort(), 8'h1C, "R11 rd+wr");
    rd(datPort(), "R11 new value");
    // R2 other addresses ignored
    wr(otherPort(), 8'h24, "R2 other idx"); wr(otherPort() + 16'd1, 8'h00, "R2 other data");
    rd(datPort(), "R2 other port no effect");
    // R5 relock
    setReg(8'h02, 8'h03, "R5 wrong code");
    chk("R5 still open", {31'd0, cfgUnlocked}, 32'd1);
    rd(datPort(), "R5 ctrl reads zero");
    busCycle(1'b1, 1'b1, datPort(), 8'h02, "R5 exit");
    chk("R5 relocked", {31'd0, cfgUnlocked}, 32'd0);
    rd(datPort(), "R5 locked after exit");
    // R2 alternate strap
    applyReset(1'b1);
    wr(16'h004E, 8'h87, "R2"); wr(16'h004E, 8'h01, "R2");
    wr(16'h004E, 8'h55, "R2"); wr(16'h004E, 8'h55, "R2 0x55 wrong for 0x4E");
    chk("R2 alt strap needs 0xAA", {31'd0, cfgUnlocked}, 32'd0);
    unlock("R2 alt strap");
    chk("R2 alt strap unlocked", {31'd0, cfgUnlocked}, 32'd1);
    getReg(8'h21, "R2 alt data port");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      logic [15:0] a;
      logic [7:0]  d;
      r = $urandom;
      case (r[2:0])
        3'd0, 3'd1, 3'd2: a = idxPort();
        3'd3, 3'd4, 3'd5: a = datPort();
        3'd6: a = otherPort() + 16'(r[3]);
        default: a = 16'h0080;
      endcase
      if (a == idxPort() && !mUnl) begin
        case (r[6:4])
          3'd0, 3'd1: d = 8'h87;
          3'd2: d = 8'h01;
          3'd3, 3'd4: d = 8'h55;
          3'd5: d = 8'hAA;
          default: d = keyOf(mCnt);
        endcase
      end else if (a == idxPort()) begin
        case (r[7:4])
          4'd0: d = 8'h02;
          4'd1, 4'd2: d = 8'h07;
          4'd3: d = 8'h20;
          4'd4: d = 8'h22;
          4'd5, 4'd6: d = 8'h24;
          4'd7, 4'd8: d = 8'h64;
          4'd9, 4'd10: d = 8'h65;
          default: d = r[15:8];
        endcase
      end else if (mIdx == 8'h07 && r[9]) d = 8'h07;
      else if (mIdx == 8'h02 && r[10]) d = 8'h02;
      else d = r[23:16];
      busCycle(r[24] | r[25], !(r[24] | r[25]) | (r[26] & r[27]), a, d, "R11 random mix");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule